// File: doc/BRIEF.md
# Cartridge ROM/RAM bank controller

This block sits between an 8-bit CPU bus and an external cartridge ROM. The CPU bus has a 16-bit address, 8-bit data and separate read and write strobes. The block maps two ROM windows into the CPU address space. The lower 16 KiB window always shows the first 16 KiB of the ROM. The upper 16 KiB window shows whichever bank the bank register selects. The block drives the full ROM address combinationally from the CPU address and the bank register. The external ROM returns a byte, and the block captures it on the clock edge of the read.

The block holds a small internal RAM of 512 locations, 4 bits wide, behind an enable gate. When the CPU reads this RAM, the stored nibble appears on the low half of the data bus and the upper half reads as zero. The CPU writes control values into the low 16 KiB of the ROM area. Address bit 8 decides whether such a write is used or ignored. In 0x0000–0x1FFF a write with bit 8 clear changes the RAM enable. In 0x2000–0x3FFF a write with bit 8 set loads the bank register.

Every access is a single-cycle synchronous access. Read data is registered, so it appears one clock after the read strobe is sampled.

Top module: `cart_bank_ctrl`

## Requirements
- R1: Out of reset the RAM is disabled, the bank register holds 1 and `cpu_rdata` reads 0xFF.
- R2: For CPU addresses 0x0000–0x3FFF, `rom_addr` equals the CPU address with its upper bits zero, whatever the bank register holds.
- R3: For CPU addresses 0x4000–0x7FFF, `rom_addr` equals bank × 0x4000 + (address − 0x4000).
- R4: On a clock edge where `cpu_rd` is high and the address is in 0x0000–0x7FFF, `cpu_rdata` takes the value of `rom_data`. On edges where `cpu_rd` is low, `cpu_rdata` holds its value.
- R5: A write to 0x0000–0x1FFF with address bit 8 clear sets the RAM enable when data bits 3:0 equal 0xA. Any other low nibble clears the enable.
- R6: A write to 0x0000–0x1FFF with address bit 8 set changes neither the RAM enable nor the bank register.
- R7: A write to 0x2000–0x3FFF with address bit 8 set loads the bank register from data bits 3:0. A value of 0 is stored as 1, so the bank register is never 0.
- R8: A write to 0x2000–0x3FFF with address bit 8 clear changes neither the bank register nor the RAM enable.
- R9: While the RAM is enabled, a write to 0xA000–0xA1FF stores data bits 3:0 at location (address − 0xA000). A read of that location returns 0000 in bits 7:4 and the stored nibble in bits 3:0.
- R10: While the RAM is disabled, writes to 0xA000–0xA1FF are dropped and reads from that range return 0xFF.
- R11: Reads from 0x8000–0x9FFF, from 0xA200–0xFFFF and from all of 0xA200 upwards return 0xFF. Writes to any address at or above 0x4000, other than the enabled RAM range, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read strobe, sampled on the clock edge |
| cpu_wr | input | 1 | Write strobe, sampled on the clock edge |
| cpu_rdata | output | 8 | Registered read data |
| rom_addr | output | 18 | Full ROM byte address (14 + bank width) |
| rom_data | input | 8 | Byte returned by the external ROM for `rom_addr` |

## Verification
The bank register is swept through all 16 data values, with varied upper data bits, and each setting is read back at the start, the end and the middle of the upper window. This separates a correct bank load from three faults: remapping 0 wrongly, using the upper data bits, and sharing a mapping with the lower window. The RAM enable is driven by all 256 data values in turn, each followed by a RAM read. This tells a low-nibble compare apart from a full-byte compare, and separates disable-on-other-values from holding the previous state. Every one of the 512 RAM locations is written with an address-dependent nibble and read back, both enabled and disabled. Writes with address bit 8 set the wrong way, and writes to unmapped addresses, are each followed by reads that would reveal any state they had changed.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

  typedef enum logic [1:0] {
    RGN_ROM_FIXED = 2'd0,
    RGN_ROM_BANKED = 2'd1,
    RGN_NIB_RAM = 2'd2,
    RGN_NONE = 2'd3
  } region_e;

  localparam int unsigned WINDOW_BITS = 14;
  localparam logic [7:0] OPEN_BUS = 8'hFF;
  localparam logic [3:0] ENABLE_KEY = 4'hA;

endpackage

// File: rtl/cbc_addr_decode.sv
module cbc_addr_decode
  import cbc_pkg::*;
#(
  parameter int unsigned RAM_BASE = 16'hA000,
  parameter int unsigned RAM_DEPTH = 512
) (
  input  logic [15:0] addr,
  input  logic        wr,
  output region_e     region,
  output logic        en_wr_evt,
  output logic        bank_wr_evt,
  output logic        ram_wr_hit
);

  function automatic region_e classify(input logic [15:0] a);
    if (a[15:14] == 2'b00) return RGN_ROM_FIXED;
    if (a[15:14] == 2'b01) return RGN_ROM_BANKED;
    if ((32'(a) >= RAM_BASE) && (32'(a) < RAM_BASE + RAM_DEPTH)) return RGN_NIB_RAM;
    return RGN_NONE;
  endfunction

  logic in_enable_zone;
  logic in_bank_zone;

  always_comb begin
    region         = classify(addr);
    in_enable_zone = (addr[15:13] == 3'b000);
    in_bank_zone   = (addr[15:13] == 3'b001);
    en_wr_evt      = wr && in_enable_zone && !addr[8];
    bank_wr_evt    = wr && in_bank_zone && addr[8];
    ram_wr_hit     = wr && (region == RGN_NIB_RAM);
  end

endmodule

// File: rtl/cbc_ctrl_regs.sv
module cbc_ctrl_regs
  import cbc_pkg::*;
#(
  parameter int unsigned BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_wr_evt,
  input  logic              bank_wr_evt,
  input  logic [3:0]        wnib,
  output logic              ram_en_q,
  output logic [BANK_W-1:0] bank_q
);

  localparam logic [BANK_W-1:0] BANK_ONE = BANK_W'(1);

  function automatic logic [BANK_W-1:0] fix_bank(input logic [BANK_W-1:0] v);
    return (v == '0) ? BANK_ONE : v;
  endfunction

  logic [BANK_W-1:0] bank_in;

  generate
    if (BANK_W >= 4) begin : g_wide
      assign bank_in = BANK_W'(wnib);
    end else begin : g_narrow
      assign bank_in = wnib[BANK_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram_en_q <= 1'b0;
      bank_q   <= BANK_ONE;
    end else begin
      if (en_wr_evt)   ram_en_q <= (wnib == ENABLE_KEY);
      if (bank_wr_evt) bank_q   <= fix_bank(bank_in);
    end
  end

endmodule

// File: rtl/cbc_nibble_ram.sv
module cbc_nibble_ram #(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned DW = 4,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cbc_pkg::*;
#(
  parameter int unsigned BANK_W = 4,
  parameter int unsigned RAM_BASE = 16'hA000,
  parameter int unsigned RAM_DEPTH = 512,
  localparam int unsigned ROM_AW = WINDOW_BITS + BANK_W,
  localparam int unsigned RAM_AW = $clog2(RAM_DEPTH),
  localparam int unsigned NIB_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic [7:0]        cpu_rdata,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [7:0]        rom_data
);

  function automatic logic [ROM_AW-1:0] map_rom(input region_e r,
                                                input logic [15:0] a,
                                                input logic [BANK_W-1:0] b);
    logic [BANK_W-1:0] sel;
    sel = (r == RGN_ROM_BANKED) ? b : '0;
    return {sel, a[WINDOW_BITS-1:0]};
  endfunction

  region_e           region;
  logic              en_wr_evt;
  logic              bank_wr_evt;
  logic              ram_wr_hit;
  logic              ram_we;
  logic              ram_en_q;
  logic [BANK_W-1:0] bank_q;
  logic [NIB_W-1:0]  ram_nib;
  logic [RAM_AW-1:0] ram_index;

  cbc_addr_decode #(.RAM_BASE(RAM_BASE), .RAM_DEPTH(RAM_DEPTH)) u_dec (
    .addr        (cpu_addr),
    .wr          (cpu_wr),
    .region      (region),
    .en_wr_evt   (en_wr_evt),
    .bank_wr_evt (bank_wr_evt),
    .ram_wr_hit  (ram_wr_hit)
  );

  cbc_ctrl_regs #(.BANK_W(BANK_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_wr_evt   (en_wr_evt),
    .bank_wr_evt (bank_wr_evt),
    .wnib        (cpu_wdata[3:0]),
    .ram_en_q    (ram_en_q),
    .bank_q      (bank_q)
  );

  assign ram_we    = ram_wr_hit && ram_en_q;
  assign ram_index = cpu_addr[RAM_AW-1:0];

  cbc_nibble_ram #(.DEPTH(RAM_DEPTH), .DW(NIB_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .addr  (ram_index),
    .wdata (cpu_wdata[NIB_W-1:0]),
    .rdata (ram_nib)
  );

  assign rom_addr = map_rom(region, cpu_addr, bank_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_rdata <= OPEN_BUS;
    end else if (cpu_rd) begin
      unique case (region)
        RGN_ROM_FIXED, RGN_ROM_BANKED: cpu_rdata <= rom_data;
        RGN_NIB_RAM: cpu_rdata <= ram_en_q ? {{(8-NIB_W){1'b0}}, ram_nib} : OPEN_BUS;
        default: cpu_rdata <= OPEN_BUS;
      endcase
    end
  end

endmodule

// File: rtl/cbc_checker.sv
module cbc_checker #(
  parameter int unsigned BANK_W = 4,
  localparam int unsigned ROM_AW = 14 + BANK_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       cpu_addr,
  input logic [7:0]        cpu_wdata,
  input logic              cpu_rd,
  input logic [7:0]        cpu_rdata,
  input logic [ROM_AW-1:0] rom_addr,
  input logic              en_wr_evt,
  input logic              bank_wr_evt,
  input logic              ram_en_q,
  input logic [BANK_W-1:0] bank_q
);

  logic ram_hit;
  logic high_unmapped;
  assign ram_hit       = (cpu_addr >= 16'hA000) && (cpu_addr < 16'hA200);
  assign high_unmapped = cpu_addr[15] && !ram_hit;

  // R7: bank loads from the low data nibble, 0 becomes 1
  p_bank_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bank_wr_evt |=> bank_q == (($past(cpu_wdata[3:0]) == 4'h0) ? BANK_W'(1) : BANK_W'($past(cpu_wdata[3:0]))));

  p_bank_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bank_q != '0);

  // R8, R6: the bank only moves on a bank write event
  p_bank_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_wr_evt |=> $stable(bank_q));

  // R5: enable compare on the low nibble only
  p_en_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr_evt |=> ram_en_q == ($past(cpu_wdata[3:0]) == 4'hA));

  // R6, R8: the enable only moves on an enable write event
  p_en_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr_evt |=> $stable(ram_en_q));

  // R2: fixed window is an identity map
  p_fixed_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b00) |-> rom_addr == ROM_AW'(cpu_addr[13:0]));

  // R3: banked window uses the bank register
  p_banked_map_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b01) |-> rom_addr == {bank_q, cpu_addr[13:0]});

  // R9: enabled RAM reads have a zero upper nibble
  p_ram_nibble_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && ram_hit && ram_en_q) |=> cpu_rdata[7:4] == 4'h0);

  // R10: disabled RAM reads float high
  p_ram_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && ram_hit && !ram_en_q) |=> cpu_rdata == 8'hFF);

  // R11: unmapped reads float high
  p_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && high_unmapped) |=> cpu_rdata == 8'hFF);

  // R4: read data holds without a read
  p_rdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rd |=> $stable(cpu_rdata));

endmodule

bind cart_bank_ctrl cbc_checker #(.BANK_W(BANK_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_addr    (cpu_addr),
  .cpu_wdata   (cpu_wdata),
  .cpu_rd      (cpu_rd),
  .cpu_rdata   (cpu_rdata),
  .rom_addr    (rom_addr),
  .en_wr_evt   (en_wr_evt),
  .bank_wr_evt (bank_wr_evt),
  .ram_en_q    (ram_en_q),
  .bank_q      (bank_q)
);

// File: tb/cart_bank_ctrl_tb.sv
module cart_bank_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  cpu_rdata;
  logic [17:0] rom_addr;
  logic [7:0]  rom_data;

  int vectors = 0;
  int misses = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] rom_byte(input logic [17:0] a);
    return a[7:0] ^ {a[17:14], a[11:8]} ^ 8'h5C;
  endfunction

  assign rom_data = rom_byte(rom_addr);

  cart_bank_ctrl u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .cpu_rdata (cpu_rdata),
    .rom_addr  (rom_addr),
    .rom_data  (rom_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  // drives a read, returns the combinational ROM address and the captured data
  task automatic bus_read(input logic [15:0] a, output int ra, output int rd);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    #1 ra = int'(rom_addr);
    @(negedge clk);
    cpu_rd = 1'b0;
    rd = int'(cpu_rdata);
  endtask

  function automatic int exp_rom_addr(input int a, input int bank);
    if (a < 16384) return a;
    return bank * 16384 + (a - 16384);
  endfunction

  task automatic check_rom(input int a, input int bank, input string req);
    int ra, rd, ea;
    ea = exp_rom_addr(a, bank);
    bus_read(16'(a), ra, rd);
    check(ra == ea, req, ra, ea);
    check(rd == int'(rom_byte(18'(ea))), {req, "/R4"}, rd, int'(rom_byte(18'(ea))));
  endtask

  task automatic check_read(input int a, input int exp, input string req);
    int ra, rd;
    bus_read(16'(a), ra, rd);
    check(rd == exp, req, rd, exp);
  endtask

  function automatic int pat(input int i, input int salt);
    return (i * 7 + salt) % 16;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin : main
    int ra, rd, b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check(int'(cpu_rdata) == 255, "R1 rdata", int'(cpu_rdata), 255);
    check_rom(16'h4000, 1, "R1 bank");
    check_read(16'hA000, 255, "R1 ram off");

    // R2/R3/R7: bank sweep
    for (int k = 0; k < 16; k++) begin
      b = (k == 0) ? 1 : k;
      bus_write(16'(16'h2100 | (k << 9 & 16'h1E00)), 8'(((k * 3) << 4) | k));
      check_rom(16'h4000, b, "R7 start");
      check_rom(16'h7FFF, b, "R3 end");
      check_rom(16384 + (k * 1237) % 16384, b, "R3 mid");
      check_rom((k * 997) % 16384, b, "R2 fixed");
    end

    // R8: bank writes with bit 8 clear are ignored
    bus_write(16'h2100, 8'h05);
    bus_write(16'h2000, 8'h09);
    bus_write(16'h3EFF, 8'h0C);
    check_rom(16'h4123, 5, "R8");

    // R5: enable sweep over all data values
    bus_write(16'h0000, 8'h0A);
    bus_write(16'hA005, 8'h06);
    for (int v = 0; v < 256; v++) begin
      bus_write(16'((v << 9) & 16'h1E00), 8'(v));
      check_read(16'hA005, ((v % 16) == 10) ? 6 : 255, "R5");
    end

    // R6: bit 8 set in the enable zone is ignored
    bus_write(16'h0000, 8'h0A);
    bus_write(16'h0100, 8'h00);
    bus_write(16'h1F00, 8'h00);
    check_read(16'hA005, 6, "R6 stays on");
    bus_write(16'h0000, 8'h00);
    bus_write(16'h0100, 8'h0A);
    check_read(16'hA005, 255, "R6 stays off");
    check_rom(16'h4000, 5, "R6 bank");

    // R9: full RAM sweep
    bus_write(16'h0000, 8'h3A);
    for (int i = 0; i < 512; i++) bus_write(16'(16'hA000 + i), 8'(16 * ((i + 5) % 16) + pat(i, 3)));
    for (int i = 0; i < 512; i++) check_read(16'hA000 + i, pat(i, 3), "R9");

    // R10: disabled RAM drops writes and reads high
    bus_write(16'h0000, 8'h00);
    for (int i = 0; i < 512; i++) bus_write(16'(16'hA000 + i), 8'(pat(i, 11)));
    for (int i = 0; i < 512; i += 37) check_read(16'hA000 + i, 255, "R10 read");
    bus_write(16'h0000, 8'h0A);
    for (int i = 0; i < 512; i += 37) check_read(16'hA000 + i, pat(i, 3), "R10 kept");

    // R11: unmapped reads and writes
    check_read(16'h8000, 255, "R11 8000");
    check_read(16'h9FFF, 255, "R11 9FFF");
    check_read(16'hA200, 255, "R11 A200");
    check_read(16'hC000, 255, "R11 C000");
    check_read(16'hFFFF, 255, "R11 FFFF");
    bus_write(16'hA000, 8'h03);
    bus_write(16'hA200, 8'h0C);
    bus_write(16'hFE00, 8'h0C);
    bus_write(16'h4100, 8'h07);
    bus_write(16'h8100, 8'h00);
    bus_write(16'hC000, 8'h00);
    check_read(16'hA000, 3, "R11 ram kept");
    check_rom(16'h4000, 5, "R11 bank kept");

    // R4: output holds while no read is issued
    bus_read(16'h0042, ra, rd);
    repeat (3) @(negedge clk);
    check(int'(cpu_rdata) == int'(rom_byte(18'h42)), "R4 hold", int'(cpu_rdata), int'(rom_byte(18'h42)));

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule